// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache with LRU Replacement

This block is a read-only cache of single words placed between a requester and a word-addressed backing memory. Each set holds two ways, and every way keeps a valid flag, a tag and one data word. A request's address is split into a set number, which is the address modulo the number of sets (the low address bits, because the set count is a power of two), and a tag, which is the remaining upper bits. Both ways of the selected set are compared at the same time, and the word of the matching way is returned.

When neither way matches, the block lowers its ready signal and issues one fetch to memory. When the memory delivers the word, the block stores it in the chosen way and returns it to the requester on the same clock edge. The chosen way is the lowest-numbered invalid way if the set has one. Otherwise it is the way that one recency bit per set marks as least recently used. A hit and a fill both count as a use of the way involved. Two running counters report how many requests completed as hits and how many as misses, so a reference string can be scored against its expected hit pattern.

Top module: `lru2_cache`

## Requirements
- R1: A synchronous active-high reset clears every valid flag, points each set's recency bit at way 0, and zeroes both counters. After reset, req_ready is 1 and rsp_valid and mem_req are 0.
- R2: The set number is the address modulo SETS and the tag is the address divided by SETS. Addresses in the same set that have different tags occupy separate entries, and at most one way of a set ever matches.
- R3: On a hit, rsp_valid is 1 for exactly one cycle, starting the cycle after acceptance, with the stored word. No memory request is raised and req_ready stays 1, so hits can be accepted on consecutive cycles.
- R4: On a miss, starting the cycle after acceptance, req_ready is 0 and mem_req is 1 with mem_addr equal to the requested address. These hold until mem_valid is sampled high.
- R5: On the edge where mem_valid is sampled during a fetch, the fill and the response happen together. rsp_valid rises carrying mem_data, mem_req falls, and req_ready returns to 1.
- R6: A fill goes into the lowest-numbered invalid way of the set, if one exists.
- R7: When both ways are valid, a fill replaces the way the set's recency bit marks as least recently used. A hit and a fill each mark the other way of that set as least recently used.
- R8: With two sets, the address string 0, 2, 0, 1, 4, 0 gives miss, miss, hit, miss, miss, hit, and the fifth access evicts 2.
- R9: hit_count and miss_count each rise by one for every completed request of their kind, in the same cycle that rsp_valid is 1.
- R10: Each accepted request produces exactly one response, and each response's data equals the memory word at the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester presents an address |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_data | output | DATA_W | Response word |
| mem_req | output | 1 | Fetch request to backing memory, held until served |
| mem_addr | output | ADDR_W | Word address to fetch |
| mem_valid | input | 1 | Backing memory delivers the fetched word |
| mem_data | input | DATA_W | Word from backing memory |
| hit_count | output | CNT_W | Number of requests completed as hits |
| miss_count | output | CNT_W | Number of requests completed as misses |

## Verification
In one clock edge the block writes the fetched word into its way, flips that set's recency bit, and launches the response. The next lookup, which may follow right after, must then see the new entry and the new recency. The bench provokes this by issuing a request the moment req_ready returns after each miss. It does this over reference strings whose hit and eviction pattern is worked out by hand, including strings where the freshly filled way or its neighbour is hit or evicted next. A scoreboard judges each response's word together with both counters at the cycle rsp_valid is seen, so a late fill, a stale recency bit or a response without a fill shows up as a wrong word or a wrong hit/miss split.

// File: rtl/lru2_cache_pkg.sv
package lru2_cache_pkg;
  typedef enum logic {
    ST_LOOK = 1'b0,
    ST_FILL = 1'b1
  } ctl_state_t;

  localparam int NUM_WAYS = 2;
endpackage

// File: rtl/lru2_way_store.sv
module lru2_way_store #(
  parameter int SETS   = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_set,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  // valid flags need a reset, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_set] <= 1'b1;
    end
  end

  // tag and data carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      data_mem[wr_set] <= wr_data;
    end
  end

  assign rd_vld  = vld_q[rd_set];
  assign rd_tag  = tag_mem[rd_set];
  assign rd_data = data_mem[rd_set];
endmodule

// File: rtl/lru2_recency.sv
module lru2_recency #(
  parameter int SETS  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_set,
  output logic             lru_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_set,
  input  logic             used_way
);
  // bit value names the least recently used way of the set
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else if (upd_en) begin
      lru_q[upd_set] <= ~used_way;
    end
  end

  assign lru_way = lru_q[rd_set];

  // R7: a use leaves the other way marked as least recent
  assert_lru_marks_other_R7: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (lru_q[$past(upd_set)] != $past(used_way)));
endmodule

// File: rtl/lru2_victim_pick.sv
module lru2_victim_pick (
  input  logic vld0,
  input  logic vld1,
  input  logic lru_way,
  output logic victim
);
  // lowest invalid way first, recency bit only when the set is full
  always_comb begin
    if (!vld0)      victim = 1'b0;
    else if (!vld1) victim = 1'b1;
    else            victim = lru_way;
  end
endmodule

// File: rtl/lru2_cache.sv
module lru2_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  import lru2_cache_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_state_t        state_q;
  logic [ADDR_W-1:0] held_addr_q;
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_set;
  logic [TAG_W-1:0]  look_tag;

  logic              way_vld  [NUM_WAYS];
  logic [TAG_W-1:0]  way_tag  [NUM_WAYS];
  logic [DATA_W-1:0] way_data [NUM_WAYS];
  logic [NUM_WAYS-1:0] hit_vec;
  logic [NUM_WAYS-1:0] way_wr;

  logic              hit_any;
  logic              hit_way;
  logic              accept;
  logic              fill_go;
  logic              lru_way;
  logic              victim;
  logic              upd_en;
  logic              used_way;
  logic [DATA_W-1:0] hit_word;

  // during a fetch the held address steers the lookup so the victim
  // is chosen from the set that missed
  assign look_addr = (state_q == ST_FILL) ? held_addr_q : req_addr;
  assign look_set  = look_addr[IDX_W-1:0];
  assign look_tag  = look_addr[ADDR_W-1:IDX_W];

  assign req_ready = (state_q == ST_LOOK);
  assign accept    = req_ready && req_valid;
  assign fill_go   = (state_q == ST_FILL) && mem_valid;

  genvar g;
  generate
    for (g = 0; g < NUM_WAYS; g++) begin : g_way
      lru2_way_store #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
      ) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_set  (look_set),
        .rd_vld  (way_vld[g]),
        .rd_tag  (way_tag[g]),
        .rd_data (way_data[g]),
        .wr_en   (way_wr[g]),
        .wr_set  (look_set),
        .wr_tag  (look_tag),
        .wr_data (mem_data)
      );
      assign hit_vec[g] = way_vld[g] && (way_tag[g] == look_tag);
      assign way_wr[g]  = fill_go && (victim == g[0]);
    end
  endgenerate

  assign hit_any  = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign hit_word = hit_way ? way_data[1] : way_data[0];

  lru2_victim_pick u_pick (
    .vld0    (way_vld[0]),
    .vld1    (way_vld[1]),
    .lru_way (lru_way),
    .victim  (victim)
  );

  assign upd_en   = (accept && hit_any) || fill_go;
  assign used_way = fill_go ? victim : hit_way;

  lru2_recency #(.SETS(SETS), .IDX_W(IDX_W)) u_recency (
    .clk      (clk),
    .rst      (rst),
    .rd_set   (look_set),
    .lru_way  (lru_way),
    .upd_en   (upd_en),
    .upd_set  (look_set),
    .used_way (used_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_LOOK;
      held_addr_q <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_LOOK: begin
          if (accept) begin
            if (hit_any) begin
              rsp_valid <= 1'b1;
              rsp_data  <= hit_word;
              hit_count <= hit_count + 1'b1;
            end else begin
              held_addr_q <= req_addr;
              mem_req     <= 1'b1;
              mem_addr    <= req_addr;
              state_q     <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_valid) begin
            rsp_valid  <= 1'b1;
            rsp_data   <= mem_data;
            miss_count <= miss_count + 1'b1;
            mem_req    <= 1'b0;
            state_q    <= ST_LOOK;
          end
        end
        default: state_q <= ST_LOOK;
      endcase
    end
  end

  // R2: two ways of one set never hold the same tag
  assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R3: an accepted hit answers next cycle without touching memory
  assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_any) |=> (rsp_valid && !mem_req && req_ready));

  // R4: an outstanding fetch stays up until memory answers
  assert_fetch_held_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && !req_ready));

  // R5: fill and response share one edge
  assert_fill_answers_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_valid) |=> (rsp_valid && !mem_req && rsp_data == $past(mem_data)));

  // R9: every response is counted exactly once
  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ({1'b0, hit_count} + {1'b0, miss_count} ==
                   {1'b0, $past(hit_count)} + {1'b0, $past(miss_count)} + 1'b1));
endmodule

// File: tb/lru2_cache_test.sv
module lru2_cache_test;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NS = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_data = '0;
  logic [CW-1:0] hit_count;
  logic [CW-1:0] miss_count;

  always #4 clk = ~clk;

  lru2_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .hit_count(hit_count), .miss_count(miss_count)
  );

  int vectors = 0;
  int miscompares = 0;
  int exp_hits = 0;
  int exp_miss = 0;

  typedef struct packed {
    logic [DW-1:0] d;
    logic          hit;
  } exp_t;
  exp_t sb[$];

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a, 4'h5, ~a, 4'hA};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // backing memory with a latency that rotates through 0..3 cycles
  initial begin : mem_model
    int lat;
    lat = 1;
    forever begin
      @(negedge clk);
      if (mem_req && !rst) begin
        repeat (lat) @(negedge clk);
        mem_data  = word_of(mem_addr);
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        lat = (lat + 1) % 4;
      end
    end
  end

  // monitor: pop expected items and compare as responses appear
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst) begin
        exp_hits = 0;
        exp_miss = 0;
      end else if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "response with nothing outstanding", rsp_data, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.hit) exp_hits++; else exp_miss++;
          check(rsp_data == e.d, e.hit ? "R3" : "R5", "response word", rsp_data, e.d);
          check(hit_count == CW'(exp_hits), "R9", "hit_count", DW'(hit_count), DW'(exp_hits));
          check(miss_count == CW'(exp_miss), "R9", "miss_count", DW'(miss_count), DW'(exp_miss));
          check(req_ready, "R5", "ready with response", DW'(req_ready), 1);
        end
      end
    end
  end

  // driver: called at a falling edge, returns at a falling edge
  task automatic issue(input logic [AW-1:0] a, input bit h);
    exp_t e;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    e.d   = word_of(a);
    e.hit = h;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (h) begin
      check(!mem_req, "R3", "hit raised mem_req", DW'(mem_req), 0);
    end else if (!rsp_valid) begin
      check(mem_req && !req_ready, "R4", "miss stall {mem_req,ready}",
            DW'({mem_req, req_ready}), DW'(2'b10));
      check(mem_addr == a, "R4", "fetch address", DW'(mem_addr), DW'(a));
    end
  endtask

  task automatic drain();
    while (sb.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    check(req_ready && !rsp_valid && !mem_req, tag, "idle {ready,rsp,mem_req}",
          DW'({req_ready, rsp_valid, mem_req}), DW'(3'b100));
    check(hit_count == '0 && miss_count == '0, tag, "counters after reset",
          DW'({hit_count, miss_count}), 0);
  endtask

  bit done = 1'b0;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R10", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");

    // R8: reference string on two sets
    issue(12'd0, 0); issue(12'd2, 0); issue(12'd0, 1);
    issue(12'd1, 0); issue(12'd4, 0); issue(12'd0, 1);
    // R6 / R7: continue; 3 fills the invalid way, others use recency
    issue(12'd2, 0); issue(12'd3, 0); issue(12'd5, 0); issue(12'd4, 0);
    issue(12'd2, 1); issue(12'd3, 1); issue(12'd5, 1); issue(12'd0, 0);
    // R3: back-to-back hits
    issue(12'd2, 1); issue(12'd3, 1); issue(12'd0, 1); issue(12'd5, 1); issue(12'd2, 1);
    // R2: same set, different tags, extreme addresses
    issue(12'h400, 0); issue(12'h402, 0); issue(12'h400, 1);
    issue(12'd2, 0); issue(12'd0, 0);
    issue(12'h7FF, 0); issue(12'h7FF, 1); issue(12'd5, 1);
    issue(12'd3, 0); issue(12'h7FF, 0);
    drain();

    // R1: reset in mid run forgets everything
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");
    issue(12'd2, 0); issue(12'd2, 1); issue(12'd4, 0); issue(12'd6, 0);
    drain();
    check(sb.size() == 0, "R10", "responses outstanding", DW'(sb.size()), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule